// File: doc/BRIEF.md
# Block Remapping Checkpoint Table

This block keeps crash-consistency metadata for non-volatile memory at cache-block granularity. Each tracked block owns a table slot that holds two NVM locations. The committed location holds the last consistent copy. The working location receives the stores of the current epoch. The first store to a block in an epoch is steered to a fresh location taken from a free-location FIFO. Later stores in the same epoch go to that same location. The committed copy is never overwritten and never copied.

Loads are translated through the table to the working location. A block that is not in the table keeps its home address. After a crash, a recovery read returns only committed locations.

A commit pulse starts a scan that visits one slot per cycle. In each visited slot the working location is promoted to committed, and the superseded committed location goes back to the tail of the free FIFO. While the scan runs, or when no slot or location is left for a store, stores are held off with ready/valid backpressure and a checkpoint request is raised.

Top module: `brt_remap_table`

## Requirements
- R1: After reset the table is empty and all 2^LOC_W locations sit in the free FIFO in ascending order. `commit_busy`, `ckpt_req` and both response valids are low, and `wr_ready` is high.
- R2: A lookup or recovery read answers one cycle after its valid. For an address with no table slot it returns remap=0 and echoes the address.
- R3: An accepted store to an untracked block takes the head of the free FIFO. It reports that location on `wr_rsp_loc` one cycle later, and later lookups return remap=1 with that location.
- R4: A second store to a block in the same epoch reports the same working location and takes nothing from the free FIFO.
- R5: A recovery read returns the committed location with remap=1 and ignores any uncommitted working location. A block that has never been committed passes through with remap=0.
- R6: A commit pulse raises `commit_busy` from the next cycle for exactly ENTRIES cycles, with `wr_ready` low throughout. Afterwards every working location is the committed location.
- R7: A commit pushes each superseded committed location onto the free FIFO tail, in ascending slot order. Locations at the home address are not pushed.
- R8: The first store of a new epoch to a committed block takes a fresh location. The committed location stays unchanged until the next commit.
- R9: A store to an untracked block while every slot is in use is not accepted, and `ckpt_req` is high. Stores to tracked blocks are still accepted.
- R10: A store that needs a fresh location while the free FIFO is empty is not accepted, and `ckpt_req` is high. A store that reuses a working location is still accepted.
- R11: A commit pulse that arrives while `commit_busy` is high is ignored, and the scan length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup block address |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_rsp_remap | output | 1 | 1: answer is an NVM location |
| lk_rsp_loc | output | LOC_W | Working location |
| lk_rsp_addr | output | ADDR_W | Echoed block address |
| wr_valid | input | 1 | Store request |
| wr_addr | input | ADDR_W | Store block address |
| wr_ready | output | 1 | Store accepted this cycle |
| wr_rsp_valid | output | 1 | Store location valid |
| wr_rsp_loc | output | LOC_W | Location the store data goes to |
| ckpt_req | output | 1 | Store blocked; a checkpoint is needed |
| commit | input | 1 | Epoch commit pulse |
| commit_busy | output | 1 | Commit scan in progress |
| rc_valid | input | 1 | Recovery read request |
| rc_addr | input | ADDR_W | Recovery block address |
| rc_rsp_valid | output | 1 | Recovery answer valid |
| rc_rsp_remap | output | 1 | 1: answer is a committed location |
| rc_rsp_loc | output | LOC_W | Committed location |
| rc_rsp_addr | output | ADDR_W | Echoed block address |

## Verification
The bench reads a block back between a new-epoch store and the next commit. A design that promoted at store time would return the new location instead of the old one. It drains the free FIFO so that a clean block's store must stall while a dirty block's store still goes through. A design that popped on every store, or blocked every store, fails one of those two checks. It tracks which locations come back after each commit and in what order. A design that freed home copies or freed in another order would hand out different locations later. It also pulses commit during a scan, where a restarting scan shows up as a longer busy window.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic {
    CS_IDLE,
    CS_SCAN
  } brt_cstate_e;

  typedef enum logic [1:0] {
    WA_NONE,
    WA_REUSE,
    WA_RENEW,
    WA_NEW
  } brt_wact_e;

endpackage

// File: rtl/brt_first_set.sv
module brt_first_set #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/brt_free_list.sv
module brt_free_list #(
  parameter int LOC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LOC_W-1:0] push_loc,
  input  logic             pop,
  output logic [LOC_W-1:0] pop_loc,
  output logic             empty
);

  localparam int DEPTH = 1 << LOC_W;
  localparam int CNT_W = LOC_W + 1;

  logic [LOC_W-1:0] slots [DEPTH];
  logic [LOC_W-1:0] rd_ptr, rd_nxt;
  logic [LOC_W-1:0] wr_ptr, wr_nxt;
  logic [CNT_W-1:0] count, count_nxt;

  always_comb begin
    rd_nxt    = pop  ? LOC_W'(rd_ptr + LOC_W'(1)) : rd_ptr;
    wr_nxt    = push ? LOC_W'(wr_ptr + LOC_W'(1)) : wr_ptr;
    count_nxt = count + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CNT_W'(DEPTH);
    end else if (push || pop) begin
      rd_ptr <= rd_nxt;
      wr_ptr <= wr_nxt;
      count  <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= LOC_W'(i);
    end else if (push) begin
      slots[wr_ptr] <= push_loc;
    end
  end

  assign pop_loc = slots[rd_ptr];
  assign empty   = (count == '0);

  // R7: returned locations never exceed the pool
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));

  // R10: nothing is taken from an empty pool
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/brt_commit_seq.sv
module brt_commit_seq
  import brt_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] step_idx
);

  brt_cstate_e      state, state_nxt;
  logic [IDX_W-1:0] idx, idx_nxt;
  logic             last;

  assign last = (idx == IDX_W'(N - 1));

  always_comb begin
    state_nxt = state;
    idx_nxt   = idx;
    unique case (state)
      CS_IDLE: if (start) begin
        state_nxt = CS_SCAN;
        idx_nxt   = '0;
      end
      CS_SCAN: begin
        if (last) state_nxt = CS_IDLE;
        else      idx_nxt   = IDX_W'(idx + IDX_W'(1));
      end
      default: state_nxt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CS_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nxt;
      idx   <= idx_nxt;
    end
  end

  assign busy     = (state == CS_SCAN);
  assign step_idx = idx;

  // R11: a pulse during the scan does not restart it
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (idx == IDX_W'($past(idx) + IDX_W'(1))));

endmodule

// File: rtl/brt_remap_table.sv
module brt_remap_table
  import brt_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOC_W   = 5,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_rsp_valid,
  output logic              lk_rsp_remap,
  output logic [LOC_W-1:0]  lk_rsp_loc,
  output logic [ADDR_W-1:0] lk_rsp_addr,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ready,
  output logic              wr_rsp_valid,
  output logic [LOC_W-1:0]  wr_rsp_loc,
  output logic              ckpt_req,
  input  logic              commit,
  output logic              commit_busy,
  input  logic              rc_valid,
  input  logic [ADDR_W-1:0] rc_addr,
  output logic              rc_rsp_valid,
  output logic              rc_rsp_remap,
  output logic [LOC_W-1:0]  rc_rsp_loc,
  output logic [ADDR_W-1:0] rc_rsp_addr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // table slots: tag, committed location (or home), working location, epoch-dirty
  logic              e_vld    [ENTRIES];
  logic [ADDR_W-1:0] e_tag    [ENTRIES];
  logic              e_home   [ENTRIES];
  logic [LOC_W-1:0]  e_ck     [ENTRIES];
  logic [LOC_W-1:0]  e_wk     [ENTRIES];
  logic              e_dirty  [ENTRIES];
  logic              n_vld    [ENTRIES];
  logic [ADDR_W-1:0] n_tag    [ENTRIES];
  logic              n_home   [ENTRIES];
  logic [LOC_W-1:0]  n_ck     [ENTRIES];
  logic [LOC_W-1:0]  n_wk     [ENTRIES];
  logic              n_dirty  [ENTRIES];

  logic [ENTRIES-1:0] lk_eq, wr_eq, rc_eq, free_vec;
  logic               lk_hit, wr_hit, rc_hit, slot_ok;
  logic [IDX_W-1:0]   lk_idx, wr_idx, rc_idx, slot_idx;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lk_eq[g]    = e_vld[g] && (e_tag[g] == lk_addr);
      assign wr_eq[g]    = e_vld[g] && (e_tag[g] == wr_addr);
      assign rc_eq[g]    = e_vld[g] && (e_tag[g] == rc_addr);
      assign free_vec[g] = !e_vld[g];
    end
  endgenerate

  brt_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_pick (
    .req(lk_eq), .found(lk_hit), .idx(lk_idx));
  brt_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_wr_pick (
    .req(wr_eq), .found(wr_hit), .idx(wr_idx));
  brt_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_rc_pick (
    .req(rc_eq), .found(rc_hit), .idx(rc_idx));
  brt_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_slot_pick (
    .req(free_vec), .found(slot_ok), .idx(slot_idx));

  // commit scan
  logic             scan_busy;
  logic [IDX_W-1:0] scan_idx;
  logic             promote;
  logic             fl_push;
  logic [LOC_W-1:0] fl_push_loc;

  brt_commit_seq #(.N(ENTRIES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(commit),
    .busy(scan_busy), .step_idx(scan_idx));

  assign promote     = scan_busy && e_vld[scan_idx] && e_dirty[scan_idx];
  assign fl_push     = promote && !e_home[scan_idx];
  assign fl_push_loc = e_ck[scan_idx];

  // store admission
  logic             dirty_hit, can_take, wr_fire, fl_pop, fl_empty;
  logic [LOC_W-1:0] fl_pop_loc;
  brt_wact_e        wact;

  brt_free_list #(.LOC_W(LOC_W)) u_free (
    .clk(clk), .rst_n(rst_n),
    .push(fl_push), .push_loc(fl_push_loc),
    .pop(fl_pop), .pop_loc(fl_pop_loc), .empty(fl_empty));

  assign dirty_hit = wr_hit && e_dirty[wr_idx];
  assign can_take  = dirty_hit || (!fl_empty && (wr_hit || slot_ok));
  assign wr_ready  = !scan_busy && !commit && can_take;
  assign ckpt_req  = wr_valid && !scan_busy && !commit && !can_take;
  assign wr_fire   = wr_valid && wr_ready;
  assign fl_pop    = wr_fire && !dirty_hit;

  always_comb begin
    if (!wr_fire)      wact = WA_NONE;
    else if (dirty_hit) wact = WA_REUSE;
    else if (wr_hit)    wact = WA_RENEW;
    else                wact = WA_NEW;
  end

  // slot next state
  always_comb begin
    n_vld   = e_vld;
    n_tag   = e_tag;
    n_home  = e_home;
    n_ck    = e_ck;
    n_wk    = e_wk;
    n_dirty = e_dirty;
    unique case (wact)
      WA_RENEW: begin
        n_wk[wr_idx]    = fl_pop_loc;
        n_dirty[wr_idx] = 1'b1;
      end
      WA_NEW: begin
        n_vld[slot_idx]   = 1'b1;
        n_tag[slot_idx]   = wr_addr;
        n_home[slot_idx]  = 1'b1;
        n_ck[slot_idx]    = '0;
        n_wk[slot_idx]    = fl_pop_loc;
        n_dirty[slot_idx] = 1'b1;
      end
      default: ;
    endcase
    if (promote) begin
      n_ck[scan_idx]    = e_wk[scan_idx];
      n_home[scan_idx]  = 1'b0;
      n_dirty[scan_idx] = 1'b0;
    end
  end

  logic slot_we;
  assign slot_we = wr_fire || promote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_vld[i]   <= 1'b0;
        e_tag[i]   <= '0;
        e_home[i]  <= 1'b1;
        e_ck[i]    <= '0;
        e_wk[i]    <= '0;
        e_dirty[i] <= 1'b0;
      end
    end else if (slot_we) begin
      e_vld   <= n_vld;
      e_tag   <= n_tag;
      e_home  <= n_home;
      e_ck    <= n_ck;
      e_wk    <= n_wk;
      e_dirty <= n_dirty;
    end
  end

  // answer next state
  logic             lk_remap_n, rc_remap_n;
  logic [LOC_W-1:0] lk_loc_n, rc_loc_n, wr_loc_n;

  always_comb begin
    lk_remap_n = lk_hit;
    lk_loc_n   = lk_hit ? e_wk[lk_idx] : '0;
    rc_remap_n = rc_hit && !e_home[rc_idx];
    rc_loc_n   = rc_remap_n ? e_ck[rc_idx] : '0;
    wr_loc_n   = dirty_hit ? e_wk[wr_idx] : fl_pop_loc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      rc_rsp_valid <= 1'b0;
      wr_rsp_valid <= 1'b0;
    end else begin
      lk_rsp_valid <= lk_valid;
      rc_rsp_valid <= rc_valid;
      wr_rsp_valid <= wr_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_rsp_remap <= 1'b0;
      lk_rsp_loc   <= '0;
      lk_rsp_addr  <= '0;
    end else if (lk_valid) begin
      lk_rsp_remap <= lk_remap_n;
      lk_rsp_loc   <= lk_loc_n;
      lk_rsp_addr  <= lk_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_rsp_remap <= 1'b0;
      rc_rsp_loc   <= '0;
      rc_rsp_addr  <= '0;
    end else if (rc_valid) begin
      rc_rsp_remap <= rc_remap_n;
      rc_rsp_loc   <= rc_loc_n;
      rc_rsp_addr  <= rc_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_rsp_loc <= '0;
    else if (wr_fire) wr_rsp_loc <= wr_loc_n;
  end

  assign commit_busy = scan_busy;

  // R3: every accepted store reports its location next cycle
  a_r3_store_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> wr_rsp_valid);

  // R2: lookup answers echo the requested address
  a_r2_echo: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_rsp_valid && lk_rsp_addr == $past(lk_addr)));

  // R6: stores are held during the scan, and a commit starts it
  a_r6_hold_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    commit_busy |-> !wr_ready);
  a_r6_scan_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !commit_busy) |=> commit_busy);

  // R9: a checkpoint request never coexists with acceptance
  a_r9_req_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_req |-> !wr_ready);

  // R4: a block has at most one slot
  a_r4_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_eq));

endmodule

// File: tb/sim_brt_remap_table.sv
`timescale 1ns/1ps
module sim_brt_remap_table;

  localparam int AW = 12;
  localparam int LW = 3;
  localparam int NE = 6;

  logic          clk, rst_n;
  logic          lk_valid, wr_valid, commit, rc_valid;
  logic [AW-1:0] lk_addr, wr_addr, rc_addr;
  logic          lk_rsp_valid, lk_rsp_remap, wr_ready, wr_rsp_valid;
  logic          ckpt_req, commit_busy, rc_rsp_valid, rc_rsp_remap;
  logic [LW-1:0] lk_rsp_loc, wr_rsp_loc, rc_rsp_loc;
  logic [AW-1:0] lk_rsp_addr, rc_rsp_addr;

  int checks = 0;
  int errors = 0;

  brt_remap_table #(.ADDR_W(AW), .LOC_W(LW), .ENTRIES(NE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_remap(lk_rsp_remap), .lk_rsp_loc(lk_rsp_loc), .lk_rsp_addr(lk_rsp_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_ready(wr_ready),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_loc(wr_rsp_loc), .ckpt_req(ckpt_req),
    .commit(commit), .commit_busy(commit_busy),
    .rc_valid(rc_valid), .rc_addr(rc_addr), .rc_rsp_valid(rc_rsp_valid),
    .rc_rsp_remap(rc_rsp_remap), .rc_rsp_loc(rc_rsp_loc), .rc_rsp_addr(rc_rsp_addr));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // op: 0 lookup, 1 store, 2 recovery read, 3 commit ; {op, addr, remap, loc}
  localparam int VW = 2 + AW + 1 + LW;
  localparam int NV = 20;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 12'h010, 1'b0, 3'd0},  // R2 miss passes through
    {2'd1, 12'h010, 1'b1, 3'd0},  // R3 head of pool
    {2'd1, 12'h020, 1'b1, 3'd1},  // R3
    {2'd0, 12'h010, 1'b1, 3'd0},  // R3 lookup remapped
    {2'd1, 12'h010, 1'b1, 3'd0},  // R4 reuse
    {2'd2, 12'h010, 1'b0, 3'd0},  // R5 never committed
    {2'd1, 12'h030, 1'b1, 3'd2},  // R4 no pop happened before
    {2'd3, 12'h000, 1'b0, 3'd0},  // R6 commit
    {2'd2, 12'h010, 1'b1, 3'd0},  // R6 promoted
    {2'd0, 12'h020, 1'b1, 3'd1},  // R6
    {2'd1, 12'h010, 1'b1, 3'd3},  // R8 fresh location in new epoch
    {2'd2, 12'h010, 1'b1, 3'd0},  // R5 uncommitted ignored
    {2'd0, 12'h010, 1'b1, 3'd3},  // R8 lookup follows working copy
    {2'd1, 12'h040, 1'b1, 3'd4},  // R3
    {2'd1, 12'h050, 1'b1, 3'd5},  // R3
    {2'd1, 12'h060, 1'b1, 3'd6},  // R3
    {2'd3, 12'h000, 1'b0, 3'd0},  // R7 frees 0 only
    {2'd2, 12'h010, 1'b1, 3'd3},  // R6
    {2'd2, 12'h040, 1'b1, 3'd4},  // R6
    {2'd2, 12'h020, 1'b1, 3'd1}   // R5 clean block keeps its copy
  };

  task automatic do_lk(input logic [AW-1:0] a, input bit rem, input int loc, input string tag);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a;
    @(negedge clk); lk_valid = 1'b0;
    chk(lk_rsp_valid && lk_rsp_remap == rem, tag, int'(lk_rsp_remap), int'(rem));
    if (rem) chk(lk_rsp_loc == LW'(loc), tag, int'(lk_rsp_loc), loc);
    else     chk(lk_rsp_addr == a, tag, int'(lk_rsp_addr), int'(a));
  endtask

  task automatic do_rc(input logic [AW-1:0] a, input bit rem, input int loc, input string tag);
    @(negedge clk); rc_valid = 1'b1; rc_addr = a;
    @(negedge clk); rc_valid = 1'b0;
    chk(rc_rsp_valid && rc_rsp_remap == rem, tag, int'(rc_rsp_remap), int'(rem));
    if (rem) chk(rc_rsp_loc == LW'(loc), tag, int'(rc_rsp_loc), loc);
    else     chk(rc_rsp_addr == a, tag, int'(rc_rsp_addr), int'(a));
  endtask

  task automatic do_wr(input logic [AW-1:0] a, input bit take, input int loc, input string tag);
    bit rdy, req;
    @(negedge clk); wr_valid = 1'b1; wr_addr = a;
    #1; rdy = wr_ready; req = ckpt_req;
    @(negedge clk);
    chk(rdy == take, tag, int'(rdy), int'(take));
    chk(req == !take, tag, int'(req), int'(!take));
    if (take) chk(wr_rsp_valid && wr_rsp_loc == LW'(loc), tag, int'(wr_rsp_loc), loc);
    else      chk(!wr_rsp_valid, tag, int'(wr_rsp_valid), 0);
    wr_valid = 1'b0;
  endtask

  task automatic do_commit(input bit retrig, input string tag);
    int n = 0;
    bit held = 1'b1;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    while (commit_busy && n < 100) begin
      n++;
      if (wr_ready) held = 1'b0;
      commit = (retrig && n == 2);
      @(negedge clk);
    end
    commit = 1'b0;
    chk(n == NE, tag, n, NE);
    chk(held, tag, int'(held), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 0; wr_valid = 0; commit = 0; rc_valid = 0;
    lk_addr = '0; wr_addr = '0; rc_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!commit_busy, "R1 busy", int'(commit_busy), 0);
    chk(wr_ready && !ckpt_req, "R1 ready", int'(wr_ready), 1);
    chk(!lk_rsp_valid && !rc_rsp_valid && !wr_rsp_valid, "R1 rsp", 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]    op;
      logic [AW-1:0] a;
      logic          rem;
      logic [LW-1:0] loc;
      {op, a, rem, loc} = VEC[i];
      case (op)
        2'd0: do_lk(a, rem, int'(loc), $sformatf("vec%0d lookup", i));
        2'd1: do_wr(a, 1'b1, int'(loc), $sformatf("vec%0d store", i));
        2'd2: do_rc(a, rem, int'(loc), $sformatf("vec%0d recover", i));
        default: do_commit(1'b0, $sformatf("vec%0d commit R6", i));
      endcase
    end

    // R9: all six slots used; new block stalls, tracked blocks still go
    do_wr(12'h070, 1'b0, 0, "R9 full table");
    do_wr(12'h020, 1'b1, 7, "R9 tracked block");
    do_wr(12'h030, 1'b1, 0, "R7 freed loc reused");
    // R10: pool now empty
    do_wr(12'h040, 1'b0, 0, "R10 empty pool clean block");
    do_wr(12'h020, 1'b1, 7, "R10 dirty block reuses");
    do_lk(12'h040, 1'b1, 4, "R10 stalled store left slot");
    // R11 + R6: retrigger during scan is ignored
    do_commit(1'b1, "R11 scan length");
    // R7: locations 1 then 2 returned in slot order
    do_wr(12'h040, 1'b1, 1, "R7 order first");
    do_wr(12'h010, 1'b1, 2, "R7 order second");
    do_rc(12'h020, 1'b1, 7, "R6 promoted after scan");
    do_rc(12'h040, 1'b1, 4, "R5 ignores new working copy");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule